// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block takes an asynchronous trigger line from outside the chip and turns it into a clean, validated level inside the timer's kernel clock domain. The raw line is first brought into the clock domain by a chain of flip-flops. It then passes through an optional edge-rate divider, which lets a fast external clock be reduced to a rate the kernel clock can track. Finally it goes through a digital noise filter that accepts a level change only after a run of consecutive samples agree on the new level.

The filter is configured by a 4-bit code. Each code selects two things at once: the sampling rate and the run length needed to accept a change. The sampling rate is either every kernel cycle, or the DTS clock-enable tick divided by 1, 2, 4, 8, 16 or 32. The block outputs the filtered level, plus one-cycle pulses that mark its rising and falling transitions. A timer uses these as a count source or as a trigger.

Top module: `etr_conditioner`

## Requirements
- R1: While reset is asserted, and until the first validated change after it, the filtered level, the rising pulse and the falling pulse are all 0.
- R2: The raw trigger passes through a 2-flop synchronizer and a 1-cycle stage. With divider select 00 and filter code 0000 with `dts_tick` held high, a change on `trig_in` reaches `trig_lvl` 4 clock cycles later.
- R3: Divider select 01, 10 and 11 make the divided signal toggle once every 1, 2 and 4 rising edges of the synchronized input. This divides its frequency by 2, 4 and 8. Select 00 passes the synchronized input through and clears the edge count.
- R4: On each sample strobe, a sample that differs from the current level increments a run counter. The level takes the new value when the run reaches N. A sample equal to the current level clears the run.
- R5: Filter code 0000 uses N=1 and samples on every `dts_tick`.
- R6: Filter codes 0001, 0010 and 0011 sample on every kernel clock cycle, with N=2, 4 and 8.
- R7: Filter codes 0100/0101, 0110/0111 and 1000/1001 sample once every 2, 4 and 8 `dts_tick` pulses. The even code of each pair uses N=6 and the odd code uses N=8.
- R8: Filter codes 1010/1011/1100 sample once every 16 `dts_tick` pulses, and codes 1101/1110/1111 once every 32. The three codes of each group use N=5, 6 and 8.
- R9: In the cycle after `flt_sel` changes value, the run counter and the tick divider are cleared, and the level keeps its value.
- R10: `trig_rise` (`trig_fall`) is high for exactly one cycle. It is high in the cycle after the one in which `trig_lvl` became 1 (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dts_tick | input | 1 | DTS-rate clock enable, one cycle wide |
| trig_in | input | 1 | Raw asynchronous external trigger |
| psc_sel | input | 2 | Edge-rate divider select (00 /1, 01 /2, 10 /4, 11 /8) |
| flt_sel | input | 4 | Filter code: sample rate and run length |
| trig_lvl | output | 1 | Filtered trigger level |
| trig_rise | output | 1 | One-cycle pulse after a rising filtered transition |
| trig_fall | output | 1 | One-cycle pulse after a falling filtered transition |

## Verification
A wrong internal state has these visible effects:
- **Run counter:** a stale or miscounted run shifts the cycle in which `trig_lvl` moves. This appears within one sample period of the mistake, or it lets a short glitch through, which is visible at once.
- **Tick divider:** a slip changes the phase of every later sample. At DTS/32 the effect on `trig_lvl` can take up to 32 × N ticks to show, so long pulses are run at the slow codes.
- **Divider edge count:** an error changes the period of the divided signal, and therefore of `trig_lvl`, within one output half-period.

A cycle-by-cycle model compares all three outputs on every clock, so any of these errors is reported in the first cycle it reaches a port.

// File: rtl/etr_pkg.sv
package etr_pkg;
   localparam int FLT_CODE_W = 4;
   localparam int NEED_W     = 4;
   localparam int DIV_LOG_W  = 3;

   typedef struct packed {
      logic                 gated;     // 1: strobe derived from dts_tick
      logic [DIV_LOG_W-1:0] div_log2;  // tick division = 2**div_log2
      logic [NEED_W-1:0]    need;      // consecutive samples to accept
   } flt_cfg_t;

   function automatic flt_cfg_t flt_decode(input logic [FLT_CODE_W-1:0] code);
      flt_cfg_t c;
      case (code)
         4'd1:    c = '{1'b0, 3'd0, 4'd2};
         4'd2:    c = '{1'b0, 3'd0, 4'd4};
         4'd3:    c = '{1'b0, 3'd0, 4'd8};
         4'd4:    c = '{1'b1, 3'd1, 4'd6};
         4'd5:    c = '{1'b1, 3'd1, 4'd8};
         4'd6:    c = '{1'b1, 3'd2, 4'd6};
         4'd7:    c = '{1'b1, 3'd2, 4'd8};
         4'd8:    c = '{1'b1, 3'd3, 4'd6};
         4'd9:    c = '{1'b1, 3'd3, 4'd8};
         4'd10:   c = '{1'b1, 3'd4, 4'd5};
         4'd11:   c = '{1'b1, 3'd4, 4'd6};
         4'd12:   c = '{1'b1, 3'd4, 4'd8};
         4'd13:   c = '{1'b1, 3'd5, 4'd5};
         4'd14:   c = '{1'b1, 3'd5, 4'd6};
         4'd15:   c = '{1'b1, 3'd5, 4'd8};
         default: c = '{1'b1, 3'd0, 4'd1};
      endcase
      return c;
   endfunction
endpackage

// File: rtl/etr_sync.sv
module etr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("etr_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= 1'b0;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/etr_prescaler.sv
module etr_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sin,
   input  logic [SEL_W-1:0] sel,
   output logic             pout
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int PCNT_W  = (MAX_SEL > 1) ? (MAX_SEL - 1) : 1;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("etr_prescaler: SEL_W out of range");
      end
   endgenerate

   logic              sin_d;
   logic              sin_rise;
   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] limit;

   assign sin_rise = sin & ~sin_d;

   always_comb begin
      limit = '0;
      if (sel != '0)
         limit = PCNT_W'((32'd1 << (int'(sel) - 1)) - 32'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_d <= 1'b0;
         pcnt  <= '0;
         pout  <= 1'b0;
      end else begin
         sin_d <= sin;
         if (sel == '0) begin
            pout <= sin;
            pcnt <= '0;
         end else if (sin_rise) begin
            if (pcnt >= limit) begin
               pout <= ~pout;
               pcnt <= '0;
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
      end
   end

   // R3: in divide mode the output only moves after a synchronized rising edge
   a_r3_toggle_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((pout != $past(pout)) && ($past(sel) != '0)) |-> $past(sin_rise));
endmodule

// File: rtl/etr_filter.sv
module etr_filter
   import etr_pkg::*;
#(
   parameter int MAX_DIV_LOG = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dts_tick,
   input  logic                  sample,
   input  logic [FLT_CODE_W-1:0] code,
   output logic                  level
);
   localparam int DIV_W = MAX_DIV_LOG;

   generate
      if (MAX_DIV_LOG < 5 || MAX_DIV_LOG >= (1 << DIV_LOG_W)) begin : g_bad_div
         $error("etr_filter: MAX_DIV_LOG must cover division by 32");
      end
   endgenerate

   flt_cfg_t                cfg;
   logic [FLT_CODE_W-1:0]   code_q;
   logic                    code_change;
   logic [DIV_W-1:0]        dcnt;
   logic [DIV_W-1:0]        div_m1;
   logic                    strobe;
   logic [NEED_W-1:0]       fcnt;
   logic [NEED_W:0]         fcnt_inc;

   assign cfg         = flt_decode(code);
   assign code_change = (code != code_q);
   assign div_m1      = DIV_W'((32'd1 << cfg.div_log2) - 32'd1);
   assign strobe      = cfg.gated ? (dts_tick && (dcnt == div_m1)) : 1'b1;
   assign fcnt_inc    = {1'b0, fcnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         dcnt   <= '0;
      end else begin
         code_q <= code;
         if (code_change)
            dcnt <= '0;
         else if (cfg.gated && dts_tick)
            dcnt <= (dcnt == div_m1) ? '0 : dcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt  <= '0;
         level <= 1'b0;
      end else if (code_change) begin
         fcnt <= '0;
      end else if (strobe) begin
         if (sample != level) begin
            if (fcnt_inc >= {1'b0, cfg.need}) begin
               level <= sample;
               fcnt  <= '0;
            end else begin
               fcnt <= fcnt_inc[NEED_W-1:0];
            end
         end else begin
            fcnt <= '0;
         end
      end
   end

   // R4: level moves only on a strobe outside a code change
   a_r4_level_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> ($past(strobe) && !$past(code_change)));
   // R4: the run never reaches N without being consumed
   a_r4_run_below_need: assert property (@(posedge clk) disable iff (!rst_n)
      !code_change |-> (fcnt < cfg.need));
   // R9: a code change clears run and divider and holds the level
   a_r9_code_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code_change) |-> ((fcnt == '0) && (dcnt == '0) && (level == $past(level))));
endmodule

// File: rtl/etr_conditioner.sv
module etr_conditioner #(
   parameter int SYNC_STAGES = 2,
   parameter int PSC_SEL_W   = 2,
   parameter int FLT_SEL_W   = 4,
   parameter int MAX_DIV_LOG = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dts_tick,
   input  logic                 trig_in,
   input  logic [PSC_SEL_W-1:0] psc_sel,
   input  logic [FLT_SEL_W-1:0] flt_sel,
   output logic                 trig_lvl,
   output logic                 trig_rise,
   output logic                 trig_fall
);
   generate
      if (FLT_SEL_W != etr_pkg::FLT_CODE_W) begin : g_bad_flt
         $error("etr_conditioner: filter code width must match the code table");
      end
   endgenerate

   logic sync_q;
   logic psc_q;
   logic lvl;
   logic lvl_d;
   logic rise_q;
   logic fall_q;

   etr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (trig_in),
      .q     (sync_q)
   );

   etr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .sin   (sync_q),
      .sel   (psc_sel),
      .pout  (psc_q)
   );

   etr_filter #(.MAX_DIV_LOG(MAX_DIV_LOG)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .dts_tick (dts_tick),
      .sample   (psc_q),
      .code     (flt_sel),
      .level    (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         lvl_d  <= lvl;
         rise_q <= lvl & ~lvl_d;
         fall_q <= ~lvl & lvl_d;
      end
   end

   assign trig_lvl  = lvl;
   assign trig_rise = rise_q;
   assign trig_fall = fall_q;

   // R10: pulses are one cycle wide, exclusive, and follow a level change
   a_r10_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rise |=> !trig_rise);
   a_r10_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      trig_fall |=> !trig_fall);
   a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_rise && trig_fall));
   a_r10_rise_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rise |-> ($past(trig_lvl) && !$past(trig_lvl, 2)));
   a_r10_fall_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
      trig_fall |-> (!$past(trig_lvl) && $past(trig_lvl, 2)));
endmodule

// File: tb/tb_etr_conditioner.sv
module tb_etr_conditioner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dts_tick = 1'b0;
   logic       trig_in = 1'b0;
   logic [1:0] psc_sel = 2'd0;
   logic [3:0] flt_sel = 4'd0;
   logic       trig_lvl, trig_rise, trig_fall;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   int    dts_mode = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   etr_conditioner dut (
      .clk(clk), .rst_n(rst_n), .dts_tick(dts_tick), .trig_in(trig_in),
      .psc_sel(psc_sel), .flt_sel(flt_sel),
      .trig_lvl(trig_lvl), .trig_rise(trig_rise), .trig_fall(trig_fall)
   );

   // ---------------- behavioural reference ----------------
   function automatic int tick_div(input int code);
      if (code == 0) return 1;
      if (code <= 3) return 0;            // 0 = every kernel cycle
      if (code <= 5) return 2;
      if (code <= 7) return 4;
      if (code <= 9) return 8;
      if (code <= 12) return 16;
      return 32;
   endfunction

   function automatic int need_of(input int code);
      case (code)
         0: return 1;  1: return 2;  2: return 4;  3: return 8;
         4, 6, 8: return 6;
         10, 13: return 5;
         11, 14: return 6;
         default: return 8;
      endcase
   endfunction

   int sync_hist[$];
   int m_rawsync, m_prev, m_edges, m_div, m_tcnt, m_code, m_run, m_lvl, m_lvl_d, m_rise, m_fall;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_hist = {0, 0};
         m_rawsync = 0; m_prev = 0; m_edges = 0; m_div = 0; m_tcnt = 0;
         m_code = 0; m_run = 0; m_lvl = 0; m_lvl_d = 0; m_rise = 0; m_fall = 0;
      end else begin
         int s, n_div, n_edges, n_tcnt, n_run, n_lvl, d, k, chg, strobe;
         s = sync_hist[1];
         n_div = m_div; n_edges = m_edges;
         if (psc_sel == 0) begin
            n_div = s; n_edges = 0;
         end else if (s == 1 && m_prev == 0) begin
            k = 1 << (int'(psc_sel) - 1);
            if (m_edges + 1 >= k) begin n_div = 1 - m_div; n_edges = 0; end
            else n_edges = m_edges + 1;
         end
         d = tick_div(flt_sel);
         chg = (int'(flt_sel) != m_code);
         strobe = (d == 0) ? 1 : (dts_tick && m_tcnt == d - 1);
         n_tcnt = m_tcnt;
         if (chg) n_tcnt = 0;
         else if (d != 0 && dts_tick) n_tcnt = (m_tcnt == d - 1) ? 0 : m_tcnt + 1;
         n_run = m_run; n_lvl = m_lvl;
         if (chg) n_run = 0;
         else if (strobe) begin
            if (m_div != m_lvl) begin
               if (m_run + 1 >= need_of(flt_sel)) begin n_lvl = m_div; n_run = 0; end
               else n_run = m_run + 1;
            end else n_run = 0;
         end
         m_rise = (m_lvl == 1 && m_lvl_d == 0);
         m_fall = (m_lvl == 0 && m_lvl_d == 1);
         m_lvl_d = m_lvl;
         m_lvl = n_lvl; m_run = n_run; m_tcnt = n_tcnt; m_code = flt_sel;
         m_div = n_div; m_edges = n_edges; m_prev = s;
         sync_hist.push_front(int'(trig_in));
         void'(sync_hist.pop_back());
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(trig_lvl == m_lvl[0], tag, "trig_lvl", int'(trig_lvl), m_lvl);
         chk(trig_rise == m_rise[0], tag, "trig_rise (R10)", int'(trig_rise), m_rise);
         chk(trig_fall == m_fall[0], tag, "trig_fall (R10)", int'(trig_fall), m_fall);
      end
   end

   always @(negedge clk) begin
      case (dts_mode)
         0: dts_tick = 1'b1;
         1: dts_tick = ($urandom % 3) == 0;
         default: dts_tick = (cyc % 2) == 0;
      endcase
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rand_run(input int cycles, input int maxw);
      int el = 0;
      while (el < cycles) begin
         int w = 1 + int'($urandom % maxw);
         trig_in = ~trig_in;
         wait_cyc(w);
         el += w;
      end
   endtask

   initial begin
      wait_cyc(3);
      chk(trig_lvl == 1'b0, "R1", "trig_lvl in reset", int'(trig_lvl), 0);
      chk(trig_rise == 1'b0 && trig_fall == 1'b0, "R1", "pulses in reset",
          int'(trig_rise) + int'(trig_fall), 0);
      rst_n = 1'b1;
      wait_cyc(4);
      chk(trig_lvl == 1'b0, "R1", "trig_lvl after reset", int'(trig_lvl), 0);

      // R2 latency with divider 00 and filter code 0000, tick every cycle
      tag = "R2"; dts_mode = 0;
      wait_cyc(4);
      trig_in = 1'b1;
      wait_cyc(3);
      chk(trig_lvl == 1'b0, "R2", "level 3 cycles after input", int'(trig_lvl), 0);
      wait_cyc(1);
      chk(trig_lvl == 1'b1, "R2", "level 4 cycles after input", int'(trig_lvl), 1);
      wait_cyc(1);
      chk(trig_rise == 1'b1, "R10", "rise pulse one cycle after level", int'(trig_rise), 1);
      rand_run(80, 6);

      // R5: code 0000 sampled on random dts ticks
      tag = "R5"; dts_mode = 1;
      rand_run(300, 8);

      // R6: kernel-rate codes
      tag = "R6";
      for (int c = 1; c <= 3; c++) begin
         flt_sel = 4'(c);
         rand_run(300, 12);
      end

      // R4: glitch shorter than N is rejected at code 0010
      tag = "R4"; flt_sel = 4'd2; trig_in = 1'b0;
      wait_cyc(30);
      trig_in = 1'b1; wait_cyc(3); trig_in = 1'b0;
      wait_cyc(12);
      chk(trig_lvl == 1'b0, "R4", "3-cycle glitch at N=4", int'(trig_lvl), 0);
      trig_in = 1'b1; wait_cyc(4); trig_in = 1'b0;
      wait_cyc(12);
      chk(trig_lvl == 1'b0, "R4", "level back low after 4-cycle pulse", int'(trig_lvl), 0);

      // R7: DTS/2, /4, /8 codes
      tag = "R7";
      for (int c = 4; c <= 9; c++) begin
         flt_sel = 4'(c);
         dts_mode = (c % 2 == 0) ? 2 : 1;
         rand_run(500, 60);
      end

      // R8: DTS/16 and /32 codes with long pulses
      tag = "R8"; dts_mode = 0;
      for (int c = 10; c <= 15; c++) begin
         flt_sel = 4'(c);
         rand_run(1500, 250);
      end

      // R9: code change in the middle of a run
      tag = "R9"; flt_sel = 4'd13; trig_in = 1'b0;
      wait_cyc(400);
      trig_in = 1'b1;
      wait_cyc(100);
      flt_sel = 4'd14;
      wait_cyc(2);
      chk(trig_lvl == 1'b0, "R9", "level held over code change", int'(trig_lvl), 0);
      wait_cyc(300);
      flt_sel = 4'd1;
      rand_run(200, 10);

      // R3: fast input clock through each divide setting
      tag = "R3"; flt_sel = 4'd1; dts_mode = 0;
      for (int p = 1; p <= 3; p++) begin
         psc_sel = 2'(p);
         for (int i = 0; i < 200; i++) begin
            trig_in = ~trig_in;
            wait_cyc(2);
         end
      end
      psc_sel = 2'd0;
      rand_run(100, 5);

      // R10: mixed settings with random dts ticks
      tag = "R10"; dts_mode = 1;
      flt_sel = 4'd0;
      rand_run(300, 4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule